// File: doc/BRIEF.md
# Vector Compare Predicate Generator

This block turns one conditional-branch style comparison into a per-element predicate mask. Each of the two source operands is named by a base register number and a flag saying whether the operand is a vector. For element index i, a vector source supplies register base+i and a scalar source supplies its base register every time. Each element comparison that holds sets bit i of the predicate result. The bits for comparisons that fail, and for indices at or above the vector length, stay zero.

If neither source is a vector, no mask is built. The block compares the two scalars once and reports a branch decision instead. Register values come through combinational read ports: one address and one data lane per element processed in a cycle. Elements are consumed `LANES` at a time, starting from index zero. A controller in the surrounding pipeline pulses `start_i` while the block is idle and waits for `done_o` (mask result) or `br_valid_o` (branch result).

Top module: `vcmp_predgen`

## Requirements
- R1: For element i, a vector source reads register (base + i) modulo `NREGS`, and a scalar source reads its base register for every element.
- R2: After a mask operation, bit i of `pred_o` is 1 exactly when i is below the effective vector length and the element comparison holds; every other bit is 0, because the mask is cleared when the operation is accepted.
- R3: The compare code on `cmp_i` selects: 3'b000 equal, 3'b001 not equal, 3'b100 signed less-than, 3'b101 signed greater-or-equal, 3'b110 unsigned less-than, 3'b111 unsigned greater-or-equal. Codes 3'b010 and 3'b011 never hold.
- R4: When both sources are scalar, `busy_o` is high for one cycle after the start cycle. In the following cycle `br_valid_o` pulses for one cycle and `br_taken_o` gives the comparison result, which is held until the next such operation. `done_o` is not asserted and `pred_o` is left unchanged.
- R5: A mask operation with effective length L > 0 keeps `busy_o` high for ceil(L/`LANES`) cycles after the start cycle. `done_o` then pulses for exactly one cycle, the final mask is on `pred_o` in that cycle, and `pred_o` holds that value until the next accepted mask operation.
- R6: A mask operation with length 0 never raises `busy_o`. It pulses `done_o` in the cycle after the start cycle, with `pred_o` equal to 0.
- R7: A requested length above `XLEN` is treated as `XLEN`.
- R8: A `start_i` pulse while `busy_o` is high is ignored and does not change the running operation or its result.
- R9: After reset, `busy_o`, `done_o`, `br_valid_o`, `br_taken_o` and `pred_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| vl_i | input | VLW | Requested vector length |
| cmp_i | input | 3 | Compare code |
| src1_base_i | input | AW | First source base register |
| src1_vec_i | input | 1 | First source is a vector |
| src2_base_i | input | AW | Second source base register |
| src2_vec_i | input | 1 | Second source is a vector |
| rd1_addr_o | output | LANES*AW | Per-lane read address, first source |
| rd1_data_i | input | LANES*XLEN | Per-lane read data, first source |
| rd2_addr_o | output | LANES*AW | Per-lane read address, second source |
| rd2_data_i | input | LANES*XLEN | Per-lane read data, second source |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Mask result ready (one-cycle pulse) |
| pred_o | output | XLEN | Predicate mask |
| br_valid_o | output | 1 | Branch result ready (one-cycle pulse) |
| br_taken_o | output | 1 | Branch comparison result |

## Verification
The bench builds the block with `XLEN` = 16, `NREGS` = 16 and `LANES` = 3. With these values a full-length mask takes six cycles and its last cycle uses only one of the three lanes. Vector sources based near the top of the register file wrap around to register 0. A 6-bit length input can also carry requests up to 63, which tests the clamp to 16. The small register file also lets the bench sweep every compare code against every combination of scalar and vector sources.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  // Compare codes; bit 2 selects ordering compares, bit 1 unsigned, bit 0 inverts.
  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vcmp_state_e;

endpackage

// File: rtl/vcmp_rst_sync.sv
module vcmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/vcmp_lane.sv
module vcmp_lane
  import vcmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      cmp_i,
  output logic            hit_o
);

  logic is_eq;
  logic is_ltu;
  logic is_lts;

  assign is_eq  = (a_i == b_i);
  assign is_ltu = (a_i < b_i);
  assign is_lts = ($signed(a_i) < $signed(b_i));

  always_comb begin
    case (cmp_i)
      CMP_EQ:  hit_o = is_eq;
      CMP_NE:  hit_o = !is_eq;
      CMP_LT:  hit_o = is_lts;
      CMP_GE:  hit_o = !is_lts;
      CMP_LTU: hit_o = is_ltu;
      CMP_GEU: hit_o = !is_ltu;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int AW    = 5,
  parameter int VLW   = 7,
  parameter int IW    = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic [2:0]     cmp_i,
  input  logic [AW-1:0]  s1_base_i,
  input  logic           s1_vec_i,
  input  logic [AW-1:0]  s2_base_i,
  input  logic           s2_vec_i,
  input  logic           hit0_i,
  output logic           busy_o,
  output logic [IW-1:0]  idx_o,
  output logic [IW-1:0]  vl_o,
  output logic [2:0]     cmp_o,
  output logic [AW-1:0]  s1_base_o,
  output logic           s1_vec_o,
  output logic [AW-1:0]  s2_base_o,
  output logic           s2_vec_o,
  output logic           clr_o,
  output logic           upd_o,
  output logic           done_o,
  output logic           br_valid_o,
  output logic           br_taken_o
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(XLEN);
  localparam logic [IW-1:0]  STEP   = IW'(LANES);

  vcmp_state_e state_q, state_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [IW-1:0]  vl_q;
  logic [2:0]     cmp_q;
  logic [AW-1:0]  b1_q, b2_q;
  logic           v1_q, v2_q, scal_q;
  logic           done_q, done_d;
  logic           brv_q, brv_d;
  logic           brt_q, brt_d;

  logic           accept;
  logic           both_scalar;
  logic [VLW-1:0] vl_cap;
  logic           last_step;

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign both_scalar = !s1_vec_i && !s2_vec_i;
  assign vl_cap      = (vl_i > VL_CAP) ? VL_CAP : vl_i;
  assign last_step   = (idx_q + STEP) >= vl_q;

  // Next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    brv_d   = 1'b0;
    brt_d   = brt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          idx_d = '0;
          if (both_scalar)        state_d = ST_RUN;
          else if (vl_cap == '0)  done_d  = 1'b1;
          else                    state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (scal_q) begin
          brv_d   = 1'b1;
          brt_d   = hit0_i;
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + STEP;
          if (last_step) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      brv_q   <= 1'b0;
      brt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      brv_q   <= brv_d;
      brt_q   <= brt_d;
    end
  end

  // Operation fields, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= '0;
      cmp_q  <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      scal_q <= 1'b0;
    end else if (accept) begin
      vl_q   <= IW'(vl_cap);
      cmp_q  <= cmp_i;
      b1_q   <= s1_base_i;
      b2_q   <= s2_base_i;
      v1_q   <= s1_vec_i;
      v2_q   <= s2_vec_i;
      scal_q <= both_scalar;
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign idx_o      = idx_q;
  assign vl_o       = vl_q;
  assign cmp_o      = cmp_q;
  assign s1_base_o  = b1_q;
  assign s1_vec_o   = v1_q;
  assign s2_base_o  = b2_q;
  assign s2_vec_o   = v2_q;
  assign clr_o      = accept && !both_scalar;
  assign upd_o      = (state_q == ST_RUN) && !scal_q;
  assign done_o     = done_q;
  assign br_valid_o = brv_q;
  assign br_taken_o = brt_q;

endmodule

// File: rtl/vcmp_pacc.sv
module vcmp_pacc #(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int IW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [LANES-1:0] hits_i,
  output logic [XLEN-1:0]  pred_o
);

  logic [XLEN-1:0] pred_q, pred_d;
  logic            pred_en;

  assign pred_en = clr_i || upd_i;

  always_comb begin
    if (clr_i) pred_d = '0;
    else       pred_d = pred_q | (XLEN'(hits_i) << idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pred_q <= '0;
    else if (pred_en) pred_q <= pred_d;
  end

  assign pred_o = pred_q;

endmodule

// File: rtl/vcmp_predgen.sv
module vcmp_predgen
  import vcmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int LANES = 4,
  localparam int AW   = $clog2(NREGS),
  localparam int VLW  = $clog2(XLEN + 1) + 1,
  localparam int IW   = $clog2(XLEN + LANES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [VLW-1:0]        vl_i,
  input  logic [2:0]            cmp_i,
  input  logic [AW-1:0]         src1_base_i,
  input  logic                  src1_vec_i,
  input  logic [AW-1:0]         src2_base_i,
  input  logic                  src2_vec_i,
  output logic [LANES*AW-1:0]   rd1_addr_o,
  input  logic [LANES*XLEN-1:0] rd1_data_i,
  output logic [LANES*AW-1:0]   rd2_addr_o,
  input  logic [LANES*XLEN-1:0] rd2_data_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [XLEN-1:0]       pred_o,
  output logic                  br_valid_o,
  output logic                  br_taken_o
);

  logic            rst_int_n;
  logic [IW-1:0]   idx;
  logic [IW-1:0]   vl_q;
  logic [2:0]      cmp_q;
  logic [AW-1:0]   b1, b2;
  logic            v1, v2;
  logic            clr, upd;
  logic [LANES-1:0] raw_hit;
  logic [LANES-1:0] act;
  logic [LANES-1:0] hits;

  vcmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  vcmp_ctrl #(
    .XLEN (XLEN), .LANES (LANES), .AW (AW), .VLW (VLW), .IW (IW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .vl_i       (vl_i),
    .cmp_i      (cmp_i),
    .s1_base_i  (src1_base_i),
    .s1_vec_i   (src1_vec_i),
    .s2_base_i  (src2_base_i),
    .s2_vec_i   (src2_vec_i),
    .hit0_i     (raw_hit[0]),
    .busy_o     (busy_o),
    .idx_o      (idx),
    .vl_o       (vl_q),
    .cmp_o      (cmp_q),
    .s1_base_o  (b1),
    .s1_vec_o   (v1),
    .s2_base_o  (b2),
    .s2_vec_o   (v2),
    .clr_o      (clr),
    .upd_o      (upd),
    .done_o     (done_o),
    .br_valid_o (br_valid_o),
    .br_taken_o (br_taken_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [AW-1:0] LOFF = AW'(l);
    localparam logic [IW-1:0] LIDX = IW'(l);
    logic [AW-1:0] a1, a2;

    assign a1 = v1 ? (b1 + AW'(idx) + LOFF) : b1;
    assign a2 = v2 ? (b2 + AW'(idx) + LOFF) : b2;
    assign rd1_addr_o[l*AW +: AW] = a1;
    assign rd2_addr_o[l*AW +: AW] = a2;

    vcmp_lane #(.XLEN (XLEN)) u_lane (
      .a_i   (rd1_data_i[l*XLEN +: XLEN]),
      .b_i   (rd2_data_i[l*XLEN +: XLEN]),
      .cmp_i (cmp_q),
      .hit_o (raw_hit[l])
    );

    assign act[l]  = (idx + LIDX) < vl_q;
    assign hits[l] = raw_hit[l] && act[l];
  end

  vcmp_pacc #(.XLEN (XLEN), .LANES (LANES), .IW (IW)) u_pacc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (clr),
    .upd_i  (upd),
    .idx_i  (idx),
    .hits_i (hits),
    .pred_o (pred_o)
  );

endmodule

// File: rtl/vcmp_predgen_chk.sv
module vcmp_predgen_chk #(
  parameter int XLEN = 32,
  parameter int VLW  = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [VLW-1:0]  vl_i,
  input logic            src1_vec_i,
  input logic            src2_vec_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            br_valid_o,
  input logic [XLEN-1:0] pred_o
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(XLEN);

  logic           accept;
  logic [VLW-1:0] vl_seen;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vl_seen <= '0;
    else if (accept) vl_seen <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_branch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_o |=> !br_valid_o);

  a_r4_no_mask_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && br_valid_o));

  a_r4_scalar_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !src1_vec_i && !src2_vec_i) |=> busy_o ##1 (br_valid_o && !busy_o));

  a_r6_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (src1_vec_i || src2_vec_i) && vl_i == '0) |=> (done_o && !busy_o && pred_o == '0));

  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((pred_o >> vl_seen) == '0));

  a_r5_pred_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(pred_o));

endmodule

bind vcmp_predgen vcmp_predgen_chk #(.XLEN (XLEN), .VLW (VLW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .vl_i       (vl_i),
  .src1_vec_i (src1_vec_i),
  .src2_vec_i (src2_vec_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .br_valid_o (br_valid_o),
  .pred_o     (pred_o)
);

// File: tb/vcmp_predgen_tb.sv
`timescale 1ns/1ps
module vcmp_predgen_tb;

  localparam int XLEN  = 16;
  localparam int NREGS = 16;
  localparam int LANES = 3;
  localparam int AW    = $clog2(NREGS);
  localparam int VLW   = $clog2(XLEN + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] vl = '0;
  logic [2:0] cmp = '0;
  logic [AW-1:0] b1 = '0, b2 = '0;
  logic v1 = 1'b0, v2 = 1'b0;
  logic [LANES*AW-1:0]   rd1_addr, rd2_addr;
  logic [LANES*XLEN-1:0] rd1_data, rd2_data;
  logic busy, done, br_valid, br_taken;
  logic [XLEN-1:0] pred;

  logic [XLEN-1:0] rf [NREGS];

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "reset";

  always #10 clk = ~clk;

  vcmp_predgen #(.XLEN (XLEN), .NREGS (NREGS), .LANES (LANES)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start), .vl_i (vl), .cmp_i (cmp),
    .src1_base_i (b1), .src1_vec_i (v1), .src2_base_i (b2), .src2_vec_i (v2),
    .rd1_addr_o (rd1_addr), .rd1_data_i (rd1_data),
    .rd2_addr_o (rd2_addr), .rd2_data_i (rd2_data),
    .busy_o (busy), .done_o (done), .pred_o (pred),
    .br_valid_o (br_valid), .br_taken_o (br_taken)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd1_data[l*XLEN +: XLEN] = rf[rd1_addr[l*AW +: AW]];
      rd2_data[l*XLEN +: XLEN] = rf[rd2_addr[l*AW +: AW]];
    end
  end

  function automatic bit ref_cmp(logic [XLEN-1:0] a, logic [XLEN-1:0] b, int c);
    case (c)
      0: return a == b;
      1: return a != b;
      4: return $signed(a) < $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a < b;
      7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0h expected %0h", tag, phase, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  bit m_busy = 0, m_done = 0, m_brv = 0, m_brt = 0, m_scal = 0, m_brt_pend = 0;
  int m_left = 0;
  logic [XLEN-1:0] m_pred = '0, m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_brv = 0; m_brt = 0; m_pred = '0; m_left = 0;
    end else begin
      m_done = 0;
      m_brv  = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          if (m_scal) begin m_brv = 1; m_brt = m_brt_pend; end
          else begin m_done = 1; m_pred = m_pend; end
        end
      end else if (start) begin
        int eff;
        eff = (int'(vl) > XLEN) ? XLEN : int'(vl);
        m_scal = !v1 && !v2;
        if (m_scal) begin
          m_brt_pend = ref_cmp(rf[b1], rf[b2], int'(cmp));
          m_busy = 1; m_left = 1;
        end else begin
          m_pend = '0;
          for (int i = 0; i < eff; i++) begin
            logic [XLEN-1:0] ea, eb;
            ea = v1 ? rf[(int'(b1) + i) % NREGS] : rf[b1];
            eb = v2 ? rf[(int'(b2) + i) % NREGS] : rf[b2];
            if (ref_cmp(ea, eb, int'(cmp))) m_pend[i] = 1'b1;
          end
          if (eff == 0) begin m_done = 1; m_pred = '0; end
          else begin m_busy = 1; m_left = (eff + LANES - 1) / LANES; end
        end
      end
    end
  end

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 busy", 32'(busy), 32'(m_busy));
      chk("R5 R6 done", 32'(done), 32'(m_done));
      chk("R4 br_valid", 32'(br_valid), 32'(m_brv));
      chk("R4 br_taken", 32'(br_taken), 32'(m_brt));
      if (!m_busy) chk("R1 R2 R3 pred", 32'(pred), 32'(m_pred));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic op(int l, int c, int s1, bit vec1, int s2, bit vec2);
    @(negedge clk);
    start = 1'b1; vl = VLW'(l); cmp = 3'(c);
    b1 = AW'(s1); v1 = vec1; b2 = AW'(s2); v2 = vec2;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int lens[6] = '{0, 1, 3, 4, 16, 40};
    for (int k = 0; k < NREGS; k++) rf[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 busy", 32'(busy), 0);
    chk("R9 done", 32'(done), 0);
    chk("R9 br_valid", 32'(br_valid), 0);
    chk("R9 br_taken", 32'(br_taken), 0);
    chk("R9 pred", 32'(pred), 0);

    // R1 R2 R3 R5 R6 R7: sweep codes, source kinds and lengths (bases wrap)
    phase = "sweep";
    for (int k = 0; k < NREGS; k++) rf[k] = XLEN'((k * 40503) ^ (k << 9));
    rf[3] = rf[14];
    rf[9] = rf[14];
    for (int c = 0; c < 8; c++)
      for (int vc = 0; vc < 3; vc++)
        for (int li = 0; li < 6; li++)
          op(lens[li], c, (c * 3 + vc * 5) % NREGS, vc != 1, 14, vc != 0);

    // R4: scalar branches for every code
    phase = "branch";
    for (int c = 0; c < 8; c++) begin
      op(5, c, 2, 0, 7, 0);
      op(5, c, 3, 0, 14, 0);
    end

    // Directed values
    phase = "directed";
    for (int k = 0; k < NREGS; k++) rf[k] = 16'h00AA;
    op(5, 0, 0, 1, 9, 0);
    chk("R2 eq mask length 5", 32'(pred), 32'h001F);
    op(40, 0, 12, 1, 9, 1);
    chk("R7 length clamped", 32'(pred), 32'hFFFF);
    op(5, 0, 4, 0, 6, 0);
    chk("R4 branch taken", 32'(br_taken), 1);
    chk("R4 pred untouched", 32'(pred), 32'hFFFF);
    op(16, 2, 0, 1, 0, 1);
    chk("R3 reserved code never holds", 32'(pred), 0);
    rf[2] = 16'h8000; rf[3] = 16'h0001;
    op(1, 4, 2, 0, 3, 0);
    chk("R3 signed lt", 32'(br_taken), 1);
    op(1, 6, 2, 0, 3, 0);
    chk("R3 unsigned lt", 32'(br_taken), 0);
    op(0, 0, 0, 1, 0, 0);
    chk("R6 zero length mask", 32'(pred), 0);

    // R8: second start during a busy operation is ignored
    phase = "R8 start while busy";
    for (int k = 0; k < NREGS; k++) rf[k] = XLEN'(k);
    @(negedge clk);
    start = 1'b1; vl = VLW'(16); cmp = 3'd6; b1 = '0; v1 = 1'b1; b2 = AW'(8); v2 = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; vl = VLW'(16); cmp = 3'd0; b1 = '0; v1 = 1'b1; b2 = '0; v2 = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    chk("R8 first result kept", 32'(pred), 32'h00FF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule